// File: doc/BRIEF.md
# Output Virtual-Channel and Credit Tracker

This block sits on one output port of a virtual-channel router and holds the state of the downstream virtual channels (VCs) behind that port. For each downstream VC it keeps an allocated flag and a count of free flit slots in the downstream input buffer. Head flits from the router's inputs ask for a VC. The block hands out at most one free VC per cycle and picks among the competing inputs in round-robin order.

Once a packet holds a VC, every flit it sends asks for permission on that VC. The send goes only when the VC is allocated and has at least one free slot, and an accepted send uses up one slot. A credit-return pulse from the downstream node gives a slot back. When a tail flit is sent, its VC is released so that a later head flit can take it. Several packets may hold different VCs at the same time, so their flits can interleave on the one physical link.

Top module: `out_vc_credit_tracker`

## Requirements
- R1: After reset every VC is free, every credit count equals DEPTH, the round-robin pointer is at requester 0 and no grant is driven.
- R2: In a cycle with head requests, exactly one requester is granted if any VC is free, and none otherwise. The granted VC is the lowest-numbered free VC, and it shows as busy from the next cycle on.
- R3: Requesters are searched in round-robin order. The search starts at requester 0 after reset and at requester i+1 (wrapping) after a grant to requester i.
- R4: A flit send is accepted (flit_go high in the same cycle) only when its VC is busy and that VC's count is nonzero. An accepted send lowers the count by one in the next cycle. A refused send leaves all state unchanged.
- R5: A credit return on a VC whose count is below DEPTH raises that count by one in the next cycle.
- R6: An accepted send and a credit return on the same VC in the same cycle leave that VC's count unchanged.
- R7: A credit return on a VC already at DEPTH, with no accepted send to that VC in the same cycle, drives crd_overflow high in that cycle and leaves the count at DEPTH. No count ever exceeds DEPTH.
- R8: An accepted send with flit_tail high frees its VC from the next cycle on.
- R9: A send aimed at a free (unallocated) VC is refused, whatever its count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| head_req | input | NUM_REQ | Per-requester head-flit VC request |
| head_gnt | output | NUM_REQ | One-hot grant to the winning requester |
| head_gnt_vc | output | VCW | VC handed to the granted requester |
| flit_valid | input | 1 | A flit asks to be sent |
| flit_vc | input | VCW | VC of the flit asking to be sent |
| flit_tail | input | 1 | The flit asking to be sent is a tail |
| flit_go | output | 1 | The send is accepted this cycle |
| crd_valid | input | 1 | Credit-return pulse from downstream |
| crd_vc | input | VCW | VC the credit belongs to |
| crd_overflow | output | 1 | Credit returned to a VC already full |
| vc_busy | output | NUM_VC | Per-VC allocated flag |
| free_cnt | output | NUM_VC*CW | Per-VC free-slot counts, VC v at bits [v*CW +: CW] |

## Verification
On every cycle the assertions check the following. Grants are one-hot or empty and only ever name a free VC, which then turns busy. Accepted sends always have a credit on an allocated VC. A same-cycle send and return on one VC holds its count. An accepted tail frees its VC. No count goes past DEPTH, and an overflowing return leaves its count at DEPTH. Only the bench's scenarios can show the choices themselves: that the lowest free VC is picked, that the round-robin order rotates correctly, that a fifth send after four is refused, that no grant appears once every VC is taken, and that reset restores full credit.

// File: rtl/out_vc_credit_tracker.sv
module out_vc_credit_tracker #(
  parameter int NUM_VC  = 4,
  parameter int DEPTH   = 4,
  parameter int NUM_REQ = 4,
  localparam int VCW = (NUM_VC  > 1) ? $clog2(NUM_VC)  : 1,
  localparam int RW  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1,
  localparam int CW  = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_REQ-1:0]   head_req,
  output logic [NUM_REQ-1:0]   head_gnt,
  output logic [VCW-1:0]       head_gnt_vc,
  input  logic                 flit_valid,
  input  logic [VCW-1:0]       flit_vc,
  input  logic                 flit_tail,
  output logic                 flit_go,
  input  logic                 crd_valid,
  input  logic [VCW-1:0]       crd_vc,
  output logic                 crd_overflow,
  output logic [NUM_VC-1:0]    vc_busy,
  output logic [NUM_VC*CW-1:0] free_cnt
);

  logic [CW-1:0] cnt [NUM_VC];
  logic [RW-1:0] ptr, win;
  logic          hit, any_free, grant;
  logic [VCW-1:0] fv;

  always_comb begin
    fv = '0;
    any_free = 1'b0;
    for (int v = NUM_VC - 1; v >= 0; v--)
      if (!vc_busy[v]) begin
        fv = VCW'(v);
        any_free = 1'b1;
      end
  end

  always_comb begin
    win = '0;
    hit = 1'b0;
    for (int k = 0; k < NUM_REQ; k++) begin
      int idx;
      idx = (int'(ptr) + k) % NUM_REQ;
      if (!hit && head_req[idx]) begin
        hit = 1'b1;
        win = RW'(idx);
      end
    end
  end

  assign grant       = hit && any_free;
  assign head_gnt    = grant ? ({{(NUM_REQ-1){1'b0}}, 1'b1} << win) : '0;
  assign head_gnt_vc = fv;

  assign flit_go      = flit_valid && vc_busy[flit_vc] && (cnt[flit_vc] != '0);
  assign crd_overflow = crd_valid && (cnt[crd_vc] == CW'(DEPTH)) &&
                        !(flit_go && (flit_vc == crd_vc));

  always_ff @(posedge clk) begin
    if (!rst_n) ptr <= '0;
    else if (grant) ptr <= (int'(win) == NUM_REQ - 1) ? '0 : win + 1'b1;
  end

  for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
    logic set, clr, dec, inc;
    assign set = grant && (fv == VCW'(v));
    assign clr = flit_go && flit_tail && (flit_vc == VCW'(v));
    assign dec = flit_go && (flit_vc == VCW'(v));
    assign inc = crd_valid && (crd_vc == VCW'(v)) && ((cnt[v] != CW'(DEPTH)) || dec);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vc_busy[v] <= 1'b0;
        cnt[v]     <= CW'(DEPTH);
      end else begin
        vc_busy[v] <= set | (vc_busy[v] & ~clr);
        if (dec && !inc)      cnt[v] <= cnt[v] - 1'b1;
        else if (inc && !dec) cnt[v] <= cnt[v] + 1'b1;
      end
    end

    assign free_cnt[v*CW +: CW] = cnt[v];
  end

endmodule

// File: rtl/vc_tracker_chk.sv
module vc_tracker_chk #(
  parameter int NUM_VC  = 4,
  parameter int DEPTH   = 4,
  parameter int NUM_REQ = 4,
  localparam int VCW = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
  localparam int CW  = $clog2(DEPTH + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_REQ-1:0]   head_gnt,
  input logic [VCW-1:0]       head_gnt_vc,
  input logic                 flit_valid,
  input logic [VCW-1:0]       flit_vc,
  input logic                 flit_tail,
  input logic                 flit_go,
  input logic                 crd_valid,
  input logic [VCW-1:0]       crd_vc,
  input logic                 crd_overflow,
  input logic [NUM_VC-1:0]    vc_busy,
  input logic [NUM_VC*CW-1:0] free_cnt
);

  p_one_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(head_gnt));

  p_grant_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
    |head_gnt |-> !vc_busy[head_gnt_vc]);

  p_grant_marks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    |head_gnt |=> vc_busy[$past(head_gnt_vc)]);

  p_go_credit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    flit_go |-> (free_cnt[flit_vc*CW +: CW] != '0));

  p_go_owned_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flit_go |-> vc_busy[flit_vc]);

  p_pair_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flit_go && crd_valid && (crd_vc == flit_vc)) |=>
    (free_cnt[$past(flit_vc)*CW +: CW] == $past(free_cnt[flit_vc*CW +: CW])));

  p_tail_frees_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flit_go && flit_tail) |=> !vc_busy[$past(flit_vc)]);

  p_ovf_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    crd_overflow |=> (free_cnt[$past(crd_vc)*CW +: CW] == CW'(DEPTH)));

  for (genvar v = 0; v < NUM_VC; v++) begin : g_chk
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      free_cnt[v*CW +: CW] <= CW'(DEPTH));
  end

endmodule

bind out_vc_credit_tracker vc_tracker_chk #(
  .NUM_VC(NUM_VC), .DEPTH(DEPTH), .NUM_REQ(NUM_REQ)
) u_chk (
  .clk(clk), .rst_n(rst_n), .head_gnt(head_gnt), .head_gnt_vc(head_gnt_vc),
  .flit_valid(flit_valid), .flit_vc(flit_vc), .flit_tail(flit_tail),
  .flit_go(flit_go), .crd_valid(crd_valid), .crd_vc(crd_vc),
  .crd_overflow(crd_overflow), .vc_busy(vc_busy), .free_cnt(free_cnt)
);

// File: tb/tb_out_vc_credit_tracker.sv
module tb_out_vc_credit_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 4, NR = 4, DP = 4, CW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NR-1:0] head_req = '0, head_gnt;
  logic [1:0] head_gnt_vc, flit_vc = '0, crd_vc = '0;
  logic flit_valid = 1'b0, flit_tail = 1'b0, flit_go, crd_valid = 1'b0, crd_overflow;
  logic [NV-1:0] vc_busy;
  logic [NV*CW-1:0] free_cnt;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  out_vc_credit_tracker #(.NUM_VC(NV), .DEPTH(DP), .NUM_REQ(NR)) dut (.*);

  typedef struct packed {
    logic [3:0]  req;
    logic        sv;
    logic [1:0]  svc;
    logic        st;
    logic        cv;
    logic [1:0]  cvc;
    logic [3:0]  egnt;
    logic [1:0]  egvc;
    logic        eok;
    logic        eerr;
    logic [3:0]  ebusy;
    logic [11:0] ecnt;
  } vec_t;

  localparam vec_t TBL [8] = '{
    '{4'b0001, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 4'b0001, 2'd0, 1'b0, 1'b0, 4'b0001, 12'h924},
    '{4'b0011, 1'b1, 2'd0, 1'b0, 1'b0, 2'd0, 4'b0010, 2'd1, 1'b1, 1'b0, 4'b0011, 12'h923},
    '{4'b0000, 1'b1, 2'd0, 1'b0, 1'b1, 2'd0, 4'b0000, 2'd0, 1'b1, 1'b0, 4'b0011, 12'h923},
    '{4'b0000, 1'b1, 2'd2, 1'b0, 1'b0, 2'd0, 4'b0000, 2'd0, 1'b0, 1'b0, 4'b0011, 12'h923},
    '{4'b0000, 1'b0, 2'd0, 1'b0, 1'b1, 2'd1, 4'b0000, 2'd0, 1'b0, 1'b1, 4'b0011, 12'h923},
    '{4'b0000, 1'b1, 2'd0, 1'b1, 1'b0, 2'd0, 4'b0000, 2'd0, 1'b1, 1'b0, 4'b0010, 12'h922},
    '{4'b1001, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 4'b1000, 2'd0, 1'b0, 1'b0, 4'b0011, 12'h922},
    '{4'b1001, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 4'b0001, 2'd2, 1'b0, 1'b0, 4'b0111, 12'h922}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] rq, input logic sv, input logic [1:0] svc,
                       input logic st, input logic cv, input logic [1:0] cvc);
    head_req = rq; flit_valid = sv; flit_vc = svc; flit_tail = st;
    crd_valid = cv; crd_vc = cvc;
    #2;
  endtask

  task automatic idle_edge();
    @(negedge clk);
    head_req = '0; flit_valid = 1'b0; flit_tail = 1'b0; crd_valid = 1'b0;
  endtask

  function automatic logic [2:0] cnt_of(input int v);
    return free_cnt[v*CW +: CW];
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 busy after reset", 32'(vc_busy), 0);
    chk("R1 counts after reset", 32'(free_cnt), 32'h924);
    chk("R1 no grant", 32'(head_gnt), 0);

    for (int i = 0; i < 8; i++) begin
      drive(TBL[i].req, TBL[i].sv, TBL[i].svc, TBL[i].st, TBL[i].cv, TBL[i].cvc);
      chk($sformatf("R2 R3 grant vec%0d", i), 32'(head_gnt), 32'(TBL[i].egnt));
      if (TBL[i].egnt != 0)
        chk($sformatf("R2 granted vc vec%0d", i), 32'(head_gnt_vc), 32'(TBL[i].egvc));
      chk($sformatf("R4 R9 go vec%0d", i), 32'(flit_go), 32'(TBL[i].eok));
      chk($sformatf("R7 overflow vec%0d", i), 32'(crd_overflow), 32'(TBL[i].eerr));
      idle_edge();
      chk($sformatf("R2 R8 busy vec%0d", i), 32'(vc_busy), 32'(TBL[i].ebusy));
      chk($sformatf("R4 R5 R6 counts vec%0d", i), 32'(free_cnt), 32'(TBL[i].ecnt));
    end

    // R3 pointer now at requester 1; last free VC is 3
    drive(4'b0010, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0);
    chk("R3 grant requester1", 32'(head_gnt), 32'b0010);
    chk("R2 grant vc3", 32'(head_gnt_vc), 3);
    idle_edge();
    chk("R2 all busy", 32'(vc_busy), 32'hf);
    drive(4'b0100, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0);
    chk("R2 no grant when none free", 32'(head_gnt), 0);
    idle_edge();
    chk("R2 busy unchanged", 32'(vc_busy), 32'hf);

    // R4 drain vc1
    for (int n = 0; n < 4; n++) begin
      drive(4'b0000, 1'b1, 2'd1, 1'b0, 1'b0, 2'd0);
      chk("R4 send with credit", 32'(flit_go), 1);
      idle_edge();
      chk("R4 count drops", 32'(cnt_of(1)), 32'(3 - n));
    end
    drive(4'b0000, 1'b1, 2'd1, 1'b0, 1'b0, 2'd0);
    chk("R4 refused at zero", 32'(flit_go), 0);
    idle_edge();
    chk("R4 count stays zero", 32'(cnt_of(1)), 0);

    drive(4'b0000, 1'b0, 2'd0, 1'b0, 1'b1, 2'd1);
    chk("R5 no overflow below depth", 32'(crd_overflow), 0);
    idle_edge();
    chk("R5 count rises", 32'(cnt_of(1)), 1);
    drive(4'b0000, 1'b1, 2'd1, 1'b1, 1'b0, 2'd0);
    chk("R4 send after return", 32'(flit_go), 1);
    idle_edge();
    chk("R8 tail frees vc1", 32'(vc_busy), 32'b1101);
    chk("R4 count back to zero", 32'(cnt_of(1)), 0);

    // R6 at full depth: send and return together on vc3
    drive(4'b0000, 1'b1, 2'd3, 1'b0, 1'b1, 2'd3);
    chk("R6 go", 32'(flit_go), 1);
    chk("R6 no overflow flag", 32'(crd_overflow), 0);
    idle_edge();
    chk("R6 count held", 32'(cnt_of(3)), 4);

    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1 busy after re-reset", 32'(vc_busy), 0);
    chk("R1 counts after re-reset", 32'(free_cnt), 32'h924);
    drive(4'b1111, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0);
    chk("R1 R3 pointer at requester0", 32'(head_gnt), 32'b0001);
    idle_edge();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule